// File: doc/BRIEF.md
# Serial Configuration Target for a Clock Generator

This block is a two-wire serial bus target that holds six 8-bit control registers for a clock generator. The controller talks to it with block transfers only. A write transfer carries a command byte and a count byte. The target acknowledges both and throws them away. Every byte after them fills the registers in rising order, starting from register 0. A read transfer returns a count byte and then the register contents in the same rising order. No register address is ever sent. A transfer always begins at the first register.

The bus lines are oversampled by a system clock that runs at least 16 times faster than SCL. Both lines pass through two flip-flops before use. Start and stop conditions are found as SDA edges while SCL is high. The open-drain SDA pin is modelled as an input, an output level (always low) and an output enable. The six register values are always visible on a flat parallel output that feeds the clock generator.

Top module: `cfgi2c_target`

## Requirements
- R1: The target acknowledges only the address bytes 0xD2 (write) and 0xD3 (read) by pulling SDA low in the ninth clock. It does not acknowledge any other address, and it stays off the bus until the next start condition.
- R2: In a write, the first and second bytes after the address (command and count) are each acknowledged and change no register.
- R3: In a write, the data bytes after the count are each acknowledged. The k-th data byte (k = 0..5) is stored in register k, and register k sits at `regs_out[8k+7:8k]`.
- R4: A stop after any complete byte ends the write. Registers already written keep their new values and the later registers keep their old ones.
- R5: Data bytes beyond the sixth are acknowledged and discarded.
- R6: A read returns first the count byte 6, then registers 0 to 5, each sent MSB first.
- R7: Bytes read past register 5 are 0xFF. After the controller does not acknowledge a byte, the target releases SDA and stays off the bus until the next start or stop.
- R8: After reset, register 0 holds 0x00, registers 1 to 5 hold 0xFF, and SDA is released.
- R9: A start or stop inside a byte aborts the transfer, and the partial byte writes nothing. A repeated start returns the target to the address phase.
- R10: The SDA output enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Active-low reset, loads the register defaults |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_o | output | 1 | Level driven on SDA when enabled (always 0) |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| regs_out | output | 48 | Registers 0..5 as a flat vector; register k sits at bits 8k+7:8k |

## Verification
The bench builds the block with its default parameters: six registers and device address 0x69, which gives the address bytes 0xD2 and 0xD3. With this register count, a transfer of eight data bytes runs past the end of the register file. A read of nine bytes reaches the 0xFF filler, so both overrun paths are exercised. The SCL quarter period is ten system clocks. This leaves room to check that the output enable only moves while the master holds SCL low.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,  // bus free or after stop
    PH_RX,    // shifting a byte in
    PH_ACK,   // holding SDA low for the ninth clock
    PH_TX,    // shifting a byte out
    PH_RACK,  // listening for controller acknowledge
    PH_IGN    // off the bus until next start/stop
  } phase_t;

  // address + command + count precede data in a write
  localparam int HDR_BYTES = 3;

  // register slot addressed by a write byte position
  function automatic int write_slot(input int pos);
    return pos - HDR_BYTES;
  endfunction

  // register slot sent for a read byte position (-1 means the count byte)
  function automatic int read_slot(input int pos);
    return pos - 2;
  endfunction

  function automatic logic addr_match(input logic [7:0] b, input logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

endpackage

// File: rtl/cfgi2c_linesync.sv
module cfgi2c_linesync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  // bit 0 = SCL, bit 1 = SDA
  logic [1:0] st1, st2, st3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1 <= 2'b11;
      st2 <= 2'b11;
      st3 <= 2'b11;
    end else begin
      st1 <= {sda_in, scl_in};
      st2 <= st1;
      st3 <= st2;
    end
  end

  assign scl_s     = st2[0];
  assign sda_s     = st2[1];
  assign scl_rise  = st2[0] & ~st3[0];
  assign scl_fall  = ~st2[0] & st3[0];
  assign start_det = st2[0] & st3[0] & st3[1] & ~st2[1];
  assign stop_det  = st2[0] & st3[0] & ~st3[1] & st2[1];

endmodule

// File: rtl/cfgi2c_regbank.sv
module cfgi2c_regbank #(
  parameter int NREG = 6,
  parameter int IW   = 3,
  parameter logic [NREG*8-1:0] DEFAULTS = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [7:0]        wr_data,
  output logic [NREG*8-1:0] regs_out
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [7:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        r <= DEFAULTS[g*8 +: 8];
      else if (wr_en && wr_idx == IW'(g))
        r <= wr_data;
    end
    assign regs_out[g*8 +: 8] = r;
  end

  // contents move only on a write strobe
  assert_hold_without_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_out));

  // the controller never aims a write past the last register
  assert_write_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_idx) < NREG));

endmodule

// File: rtl/cfgi2c_target.sv
module cfgi2c_target #(
  parameter int                NREG     = 6,
  parameter logic [6:0]        DEV_ADDR = 7'h69,
  parameter logic [NREG*8-1:0] DEFAULTS = {{(NREG-1){8'hFF}}, 8'h00}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_o,
  output logic              sda_oe,
  output logic [NREG*8-1:0] regs_out
);
  import cfgi2c_pkg::*;

  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int BW = $clog2(NREG + HDR_BYTES + 1) + 1;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  cfgi2c_linesync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  phase_t          ph;
  logic [3:0]      bit_cnt;
  logic [7:0]      rx_sh, tx_sh;
  logic [BW-1:0]   pos;      // byte position in transfer, saturating
  logic            rw;       // 1 = read transfer
  logic            mack;     // controller acknowledged last sent byte
  logic [7:0]      rd_byte;
  logic            wr_en;
  logic [IW-1:0]   wr_idx;
  logic            byte_done;
  int              wslot, rslot;

  assign sda_o     = 1'b0;
  assign byte_done = (ph == PH_RX) && scl_fall && (bit_cnt == 4'd8);

  always_comb begin
    wslot  = write_slot(int'(pos));
    wr_en  = byte_done && !rw && (wslot >= 0) && (wslot < NREG);
    wr_idx = IW'(wslot);
  end

  always_comb begin
    rslot = read_slot(int'(pos));
    if (rslot < 0)         rd_byte = 8'(NREG);
    else if (rslot < NREG) rd_byte = regs_out[rslot*8 +: 8];
    else                   rd_byte = 8'hFF;
  end

  cfgi2c_regbank #(.NREG(NREG), .IW(IW), .DEFAULTS(DEFAULTS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(rx_sh), .regs_out(regs_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; sda_oe <= 1'b0; bit_cnt <= '0; rx_sh <= '0;
      tx_sh <= '0; pos <= '0; rw <= 1'b0; mack <= 1'b0;
    end else if (start_det) begin
      ph <= PH_RX; sda_oe <= 1'b0; bit_cnt <= '0; pos <= '0; rw <= 1'b0;
    end else if (stop_det) begin
      ph <= PH_IDLE; sda_oe <= 1'b0;
    end else begin
      unique case (ph)
        PH_RX: begin
          if (scl_rise && bit_cnt != 4'd8) begin
            rx_sh   <= {rx_sh[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_done) begin
            if (pos == '0 && !addr_match(rx_sh, DEV_ADDR)) begin
              ph <= PH_IGN;
            end else begin
              sda_oe <= 1'b1;
              ph     <= PH_ACK;
              if (pos == '0) rw <= rx_sh[0];
              if (pos != '1) pos <= pos + 1'b1;
            end
          end
        end
        PH_ACK, PH_RACK: begin
          if (ph == PH_RACK && scl_rise) mack <= !sda_s;
          if (scl_fall) begin
            bit_cnt <= '0;
            if (ph == PH_RACK && !mack) begin
              ph <= PH_IGN;
            end else if (rw) begin
              tx_sh  <= rd_byte;
              sda_oe <= !rd_byte[7];
              ph     <= PH_TX;
              if (pos != '1) pos <= pos + 1'b1;
            end else begin
              sda_oe <= 1'b0;
              ph     <= PH_RX;
            end
          end
        end
        PH_TX: begin
          if (scl_fall) begin
            if (bit_cnt == 4'd7) begin
              sda_oe <= 1'b0;
              ph     <= PH_RACK;
            end else begin
              tx_sh   <= {tx_sh[6:0], 1'b0};
              sda_oe  <= !tx_sh[6];
              bit_cnt <= bit_cnt + 4'd1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // a rejected transfer keeps the target silent
  assert_ignore_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_IGN) |-> !sda_oe);

  // an idle bus is never pulled low by the target
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_IDLE) |-> !sda_oe);

  // data line changes only in the SCL low phase
  assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det)));

endmodule

// File: tb/cfgi2c_target_test.sv
module cfgi2c_target_test;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic m_low = 1'b0;
  logic sda_o, sda_oe;
  logic [47:0] regs_out;
  wire  sda_bus = ~(m_low | sda_oe);

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int r10_viol = 0;
  logic prev_oe = 1'b0;
  logic [7:0] exp_r [6];

  always #10 clk = ~clk;

  cfgi2c_target uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .sda_o(sda_o), .sda_oe(sda_oe), .regs_out(regs_out)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog act=%0d exp<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n && sda_oe != prev_oe && scl_m) r10_viol = r10_viol + 1;
    prev_oe = sda_oe;
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_regs(input string tag);
    for (int i = 0; i < 6; i++) chk(tag, regs_out[i*8 +: 8], exp_r[i]);
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    m_low = ~b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bit_in(output logic b);
    m_low = 1'b0; wq(); scl_m = 1'b1; wq(); b = sda_bus; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic byte_out(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b);
    ack = !b;
  endtask

  task automatic byte_in(input logic give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_in(b); d[i] = b; end
    bit_out(!give_ack);
  endtask

  task automatic i2c_start();
    m_low = 1'b0; wq(); scl_m = 1'b1; wq(); m_low = 1'b1; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; wq(); scl_m = 1'b1; wq(); m_low = 1'b0; wq();
  endtask

  task automatic write_hdr(input string tag);
    logic a;
    i2c_start();
    byte_out(8'hD2, a); chk({tag, " R1 addr ack"}, 8'(a), 8'd1);
    byte_out(8'h5C, a); chk({tag, " R2 cmd ack"}, 8'(a), 8'd1);
    byte_out(8'h06, a); chk({tag, " R2 count ack"}, 8'(a), 8'd1);
  endtask

  task automatic t_reset();
    chk("R8 oe after reset", 8'(sda_oe), 8'd0);
    for (int i = 0; i < 6; i++) exp_r[i] = (i == 0) ? 8'h00 : 8'hFF;
    chk_regs("R8 defaults");
  endtask

  task automatic t_full_write();
    logic a;
    logic [7:0] d [6] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    write_hdr("full");
    chk_regs("R2 header leaves regs");
    for (int i = 0; i < 6; i++) begin
      byte_out(d[i], a); chk("R3 data ack", 8'(a), 8'd1);
      exp_r[i] = d[i];
    end
    i2c_stop();
    chk_regs("R3 full write");
  endtask

  task automatic t_partial();
    logic a;
    write_hdr("partial");
    byte_out(8'hA1, a); byte_out(8'hB2, a);
    i2c_stop();
    exp_r[0] = 8'hA1; exp_r[1] = 8'hB2;
    chk_regs("R4 partial write");
  endtask

  task automatic t_overflow();
    logic a;
    write_hdr("over");
    for (int i = 0; i < 8; i++) begin
      byte_out(8'hC0 + 8'(i), a);
      if (i >= 6) chk("R5 extra byte ack", 8'(a), 8'd1);
      if (i < 6) exp_r[i] = 8'hC0 + 8'(i);
    end
    i2c_stop();
    chk_regs("R5 extra discarded");
  endtask

  task automatic t_read();
    logic a;
    logic [7:0] d;
    i2c_start();
    byte_out(8'hD3, a); chk("R1 read addr ack", 8'(a), 8'd1);
    byte_in(1'b1, d); chk("R6 count byte", d, 8'd6);
    for (int i = 0; i < 6; i++) begin
      byte_in(1'b1, d); chk("R6 reg readback", d, exp_r[i]);
    end
    byte_in(1'b1, d); chk("R7 past end", d, 8'hFF);
    byte_in(1'b0, d); chk("R7 past end nack", d, 8'hFF);
    chk("R7 released after nack", 8'(sda_oe), 8'd0);
    i2c_stop();
    chk("R7 released after stop", 8'(sda_oe), 8'd0);
  endtask

  task automatic t_bad_addr();
    logic a;
    i2c_start();
    byte_out(8'hA0, a); chk("R1 foreign addr nack", 8'(a), 8'd0);
    byte_out(8'h00, a); chk("R1 silent after nack", 8'(a), 8'd0);
    byte_out(8'h06, a); byte_out(8'h99, a); byte_out(8'h98, a);
    chk("R1 still silent", 8'(a), 8'd0);
    i2c_stop();
    chk_regs("R1 foreign write ignored");
  endtask

  task automatic t_abort();
    logic a;
    logic [7:0] d;
    write_hdr("abort");
    bit_out(1'b0); bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
    i2c_stop();
    chk_regs("R9 stop mid byte");
    write_hdr("rstart");
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
    i2c_start();
    byte_out(8'hD3, a); chk("R9 addr after repeated start", 8'(a), 8'd1);
    byte_in(1'b1, d); chk("R9 count after repeated start", d, 8'd6);
    byte_in(1'b0, d); chk("R9 reg0 unchanged", d, exp_r[0]);
    i2c_stop();
    chk_regs("R9 repeated start mid byte");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_full_write();
    t_partial();
    t_overflow();
    t_read();
    t_bad_addr();
    t_abort();
    chk("R10 oe moves only with SCL low", 8'(r10_viol), 8'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule